// File: doc/BRIEF.md
# Per-Input Phase-Lock Timeout Alarm

This block watches how long a reference-clock selector takes to phase-lock onto its currently chosen input. It counts one-second ticks while the selected input has not locked. If the count reaches a programmable period, it sets a sticky alarm flag for that input. Each of the inputs has its own flag. A flagged input is reported as disqualified, so that the selection logic elsewhere can skip it.

The period is a 6-bit count scaled by a power-of-two factor chosen by a 2-bit field. A period of zero turns alarm raising off. A mode bit chooses how alarms go away:
- In write-one-to-clear mode, a per-input strobe clears the flag.
- In self-expiry mode, each flag clears itself one period after it was raised. Each flag uses its own expiry counter, and strobes are ignored in this mode.

Top module: `phlock_alarm_top`

## Requirements
- R1: After reset every `alarm` and `disqual` bit is 0.
- R2: The period P, in ticks, is `timeout_val` times 1, 2, 4 or 8 for `mult_sel` equal to 0, 1, 2 or 3.
- R3: The lock timer counts `sec_tick` pulses while unlocked. On the P-th counted tick, `alarm[s]` for the selected index s (0 to N-1) is 1 on the next cycle. A selected index of N or above raises nothing.
- R4: The lock timer is cleared in every cycle where `phase_locked` is 1. It is also cleared in a cycle where `sel_idx` differs from its value in the previous cycle, and ticks in that cycle are not counted.
- R5: While P is 0, no alarm is raised.
- R6: With `auto_clr_mode`=0, `w1c_strobe[i]`=1 clears `alarm[i]` on the next cycle.
- R7: With `auto_clr_mode`=1, a set alarm clears on the cycle after the P-th tick that follows its raise. Each input keeps its own expiry count.
- R8: With `auto_clr_mode`=1, `w1c_strobe` has no effect on `alarm`.
- R9: A raise and a clear strobe for the same input in the same cycle leave the alarm set.
- R10: `disqual[i]` is 1 exactly when `alarm[i]` is 1.
- R11: After a raise, the lock timer restarts from zero. Continued failure raises again after P more ticks, and that re-raise restarts the input's expiry count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| sel_idx | input | 4 | Index of the currently selected input |
| phase_locked | input | 1 | Selected input is phase-locked |
| timeout_val | input | 6 | Base timeout count |
| mult_sel | input | 2 | Power-of-two scale of the timeout |
| auto_clr_mode | input | 1 | 0: write-one-to-clear, 1: self-expiry |
| w1c_strobe | input | 12 | Per-input clear strobes |
| alarm | output | 12 | Per-input alarm flags |
| disqual | output | 12 | Per-input disqualification |

## Verification
The main collisions are a raise landing on the same cycle as a clear of the same input. In write-one-to-clear mode that clear is a strobe. In self-expiry mode it is a final expiry tick that coincides with a re-raise. Directed cases use a one-tick period so that every tick raises, and they drive the strobe on that tick. Random runs mix short periods, dense ticks and sparse strobes so that such collisions recur. Every cycle is compared against a cycle-accurate expectation computed in the bench. Checks expect the flag to stay set and the expiry count to restart.

// File: rtl/phla_pkg.sv
package phla_pkg;
    typedef enum logic {
        CLR_BY_WRITE = 1'b0,
        CLR_BY_TIME  = 1'b1
    } clr_mode_e;
endpackage

// File: rtl/phla_period.sv
module phla_period #(
    parameter int CNT_W = 6,
    parameter int MUL_W = 2,
    localparam int PER_W = CNT_W + (1 << MUL_W) - 1
) (
    input  logic [CNT_W-1:0] base_cnt,
    input  logic [MUL_W-1:0] scale,
    output logic [PER_W-1:0] period
);
    // Scale is a left shift: x1, x2, x4, x8 for the default 2-bit field
    always_comb begin
        period = {{(PER_W-CNT_W){1'b0}}, base_cnt} << scale;
    end
endmodule

// File: rtl/phla_lock_timer.sv
module phla_lock_timer #(
    parameter int N_INPUTS = 12,
    parameter int IDX_W    = 4,
    parameter int PER_W    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sec_tick,
    input  logic                phase_locked,
    input  logic [IDX_W-1:0]    sel_idx,
    input  logic [PER_W-1:0]    period,
    output logic [N_INPUTS-1:0] raise_vec,
    output logic [PER_W-1:0]    cnt_o
);
    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic [IDX_W-1:0] prev;
    } tmr_t;

    tmr_t st_d, st_q;
    logic hit_d;
    logic sel_moved;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sel_idx;
        hit_d     = 1'b0;
        sel_moved = (sel_idx != st_q.prev);
        if (phase_locked || sel_moved || (period == '0)) begin
            st_d.cnt = '0;
        end else if (sec_tick) begin
            if (({1'b0, st_q.cnt} + {{PER_W{1'b0}}, 1'b1}) >= {1'b0, period}) begin
                st_d.cnt = '0;
                hit_d    = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar gi = 0; gi < N_INPUTS; gi++) begin : g_dec
        assign raise_vec[gi] = hit_d && (sel_idx == IDX_W'(gi));
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/phla_alarm_slot.sv
module phla_alarm_slot #(
    parameter int PER_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic             auto_mode,
    input  logic             w1c,
    input  logic             raise,
    input  logic [PER_W-1:0] period,
    output logic             alarm_o
);
    typedef struct packed {
        logic             alarm;
        logic [PER_W-1:0] age;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (raise) begin
            st_d.alarm = 1'b1;
            st_d.age   = '0;
        end else if (st_q.alarm) begin
            if (auto_mode) begin
                if (sec_tick) begin
                    if (({1'b0, st_q.age} + {{PER_W{1'b0}}, 1'b1}) >= {1'b0, period}) begin
                        st_d.alarm = 1'b0;
                        st_d.age   = '0;
                    end else begin
                        st_d.age = st_q.age + 1'b1;
                    end
                end
            end else if (w1c) begin
                st_d.alarm = 1'b0;
                st_d.age   = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alarm_o = st_q.alarm;
endmodule

// File: rtl/phlock_alarm_top.sv
module phlock_alarm_top #(
    parameter int N_INPUTS = 12,
    parameter int CNT_W    = 6,
    parameter int MUL_W    = 2,
    localparam int IDX_W   = $clog2(N_INPUTS + 1),
    localparam int PER_W   = CNT_W + (1 << MUL_W) - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sec_tick,
    input  logic [IDX_W-1:0]    sel_idx,
    input  logic                phase_locked,
    input  logic [CNT_W-1:0]    timeout_val,
    input  logic [MUL_W-1:0]    mult_sel,
    input  logic                auto_clr_mode,
    input  logic [N_INPUTS-1:0] w1c_strobe,
    output logic [N_INPUTS-1:0] alarm,
    output logic [N_INPUTS-1:0] disqual
);
    import phla_pkg::*;

    logic [PER_W-1:0]    period_w;
    logic [N_INPUTS-1:0] raise_w;
    logic [PER_W-1:0]    lock_cnt_w;
    logic                by_time;

    assign by_time = (clr_mode_e'(auto_clr_mode) == CLR_BY_TIME);

    phla_period #(.CNT_W(CNT_W), .MUL_W(MUL_W)) u_period (
        .base_cnt (timeout_val),
        .scale    (mult_sel),
        .period   (period_w)
    );

    phla_lock_timer #(.N_INPUTS(N_INPUTS), .IDX_W(IDX_W), .PER_W(PER_W)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .sec_tick     (sec_tick),
        .phase_locked (phase_locked),
        .sel_idx      (sel_idx),
        .period       (period_w),
        .raise_vec    (raise_w),
        .cnt_o        (lock_cnt_w)
    );

    for (genvar gi = 0; gi < N_INPUTS; gi++) begin : g_slot
        phla_alarm_slot #(.PER_W(PER_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .sec_tick  (sec_tick),
            .auto_mode (by_time),
            .w1c       (w1c_strobe[gi]),
            .raise     (raise_w[gi]),
            .period    (period_w),
            .alarm_o   (alarm[gi])
        );
    end

    assign disqual = alarm;
endmodule

// File: rtl/phla_alarm_chk.sv
module phla_alarm_chk #(
    parameter int N_INPUTS = 12,
    parameter int PER_W    = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sec_tick,
    input logic                phase_locked,
    input logic                auto_clr_mode,
    input logic [N_INPUTS-1:0] w1c_strobe,
    input logic [N_INPUTS-1:0] alarm,
    input logic [PER_W-1:0]    period_w,
    input logic [N_INPUTS-1:0] raise_w,
    input logic [PER_W-1:0]    lock_cnt_w
);
    // R3
    raise_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(raise_w));

    // R5
    zero_period_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_w == '0) |-> (raise_w == '0));

    // R4
    locked_clears_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_locked |=> (lock_cnt_w == '0));

    // R6
    strobe_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_clr_mode |=> ((alarm & $past(w1c_strobe & ~raise_w)) == '0));

    // R8
    auto_ignores_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_clr_mode && !sec_tick && (raise_w == '0)) |=> $stable(alarm));

    // R9
    raise_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_w != '0) |=> ((alarm & $past(raise_w)) == $past(raise_w)));
endmodule

bind phlock_alarm_top phla_alarm_chk #(.N_INPUTS(N_INPUTS), .PER_W(PER_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sec_tick      (sec_tick),
    .phase_locked  (phase_locked),
    .auto_clr_mode (auto_clr_mode),
    .w1c_strobe    (w1c_strobe),
    .alarm         (alarm),
    .period_w      (period_w),
    .raise_w       (raise_w),
    .lock_cnt_w    (lock_cnt_w)
);

// File: tb/phlock_alarm_top_test.sv
module phlock_alarm_top_test;
    localparam int N = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [3:0]  sel = '0;
    logic        locked = 1'b0;
    logic [5:0]  tv = '0;
    logic [1:0]  ms = '0;
    logic        auto = 1'b0;
    logic [N-1:0] w1c = '0;
    logic [N-1:0] alarm, disqual;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    int m_cnt = 0;
    int m_prev = 0;
    bit m_al [N];
    int m_age [N];

    phlock_alarm_top uut (
        .clk(clk), .rst_n(rst_n), .sec_tick(tick), .sel_idx(sel),
        .phase_locked(locked), .timeout_val(tv), .mult_sel(ms),
        .auto_clr_mode(auto), .w1c_strobe(w1c), .alarm(alarm), .disqual(disqual)
    );

    always #10 clk = ~clk;

    function automatic int exp_period(input int v, input int m);
        int f;
        case (m)
            0: f = 1;
            1: f = 2;
            2: f = 4;
            default: f = 8;
        endcase
        return v * f;
    endfunction

    function automatic logic [N-1:0] model_vec();
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = m_al[i];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, expv, $time);
        end
    endtask

    task automatic step(input string tag);
        int p;
        bit chg, hit;
        @(posedge clk);
        p   = exp_period(int'(tv), int'(ms));
        chg = (int'(sel) != m_prev);
        hit = 0;
        if (locked || chg || p == 0) m_cnt = 0;
        else if (tick) begin
            if (m_cnt + 1 >= p) begin m_cnt = 0; hit = 1; end
            else m_cnt++;
        end
        m_prev = int'(sel);
        for (int i = 0; i < N; i++) begin
            if (hit && int'(sel) == i) begin
                m_al[i] = 1; m_age[i] = 0;
            end else if (m_al[i]) begin
                if (auto) begin
                    if (tick) begin
                        if (m_age[i] + 1 >= p) begin m_al[i] = 0; m_age[i] = 0; end
                        else m_age[i]++;
                    end
                end else if (w1c[i]) begin
                    m_al[i] = 0; m_age[i] = 0;
                end
            end
        end
        @(negedge clk);
        chk(tag, alarm, model_vec());
        chk("R10", disqual, model_vec());
    endtask

    task automatic ticks(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            tick = 1'b1;
            step(tag);
        end
        tick = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < N; i++) begin m_al[i] = 0; m_age[i] = 0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", alarm, '0);
        chk("R1", disqual, '0);
        rst_n = 1'b1;

        // R2/R3: P = 2*4 = 8; alarm on input 2 after the 8th tick
        tv = 6'd2; ms = 2'd2; sel = 4'd2; auto = 1'b0;
        step("R3");
        ticks(7, "R2");
        chk("R2", alarm, '0);
        ticks(1, "R2");
        chk("R3", alarm, 12'h004);

        // R6: strobe clears in write mode
        w1c = 12'h004; step("R6"); w1c = '0;
        chk("R6", alarm, '0);

        // R4: locked holds timer clear; selection change restarts
        locked = 1'b1; ticks(20, "R4"); locked = 1'b0;
        chk("R4", alarm, '0);
        ticks(5, "R4");
        sel = 4'd7; step("R4");
        ticks(7, "R4");
        chk("R4", alarm, '0);
        ticks(1, "R4");
        chk("R4", alarm, 12'h080);
        w1c = '1; step("R6"); w1c = '0;

        // R5: zero period raises nothing
        tv = 6'd0; ms = 2'd3; ticks(40, "R5");
        chk("R5", alarm, '0);

        // R3: index beyond range raises nothing
        tv = 6'd1; ms = 2'd0; sel = 4'd13; step("R3");
        ticks(10, "R3");
        chk("R3", alarm, '0);

        // R9: raise coincides with strobe (P = 1)
        sel = 4'd5; step("R9");
        tick = 1'b1; w1c = 12'h020; step("R9");
        chk("R9", alarm, 12'h020);
        step("R9"); tick = 1'b0; w1c = '0;
        chk("R9", alarm, 12'h020);
        w1c = 12'h020; step("R6"); w1c = '0;

        // R7/R8: self-expiry with P = 3, strobes ignored
        auto = 1'b1; tv = 6'd3; ms = 2'd0; sel = 4'd0; step("R7");
        ticks(3, "R7");
        chk("R7", alarm, 12'h001);
        locked = 1'b1;
        w1c = '1; step("R8"); w1c = '0;
        chk("R8", alarm, 12'h001);
        ticks(2, "R7");
        chk("R7", alarm, 12'h001);
        ticks(1, "R7");
        chk("R7", alarm, 12'h000);
        locked = 1'b0;

        // R11: repeated failure re-raises and restarts expiry
        sel = 4'd9; step("R11");
        ticks(3, "R11");
        chk("R11", alarm, 12'h200);
        ticks(3, "R11");
        chk("R11", alarm, 12'h200);
        locked = 1'b1; ticks(2, "R11");
        chk("R11", alarm, 12'h200);
        ticks(1, "R11");
        chk("R11", alarm, 12'h000);
        locked = 1'b0;

        // Mixed random traffic
        for (int k = 0; k < 4000; k++) begin
            tick   = ($urandom_range(0, 1) == 1);
            locked = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 19) == 0) sel = 4'($urandom_range(0, 13));
            if ($urandom_range(0, 99) == 0) tv = 6'($urandom_range(0, 4));
            if ($urandom_range(0, 99) == 0) ms = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 299) == 0) auto = ~auto;
            w1c = ($urandom_range(0, 5) == 0) ? N'($urandom) : '0;
            step("R11");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule